// File: doc/BRIEF.md
# Plane Scroll Offset Selector

This block turns a screen position into a position on a background plane. For each request it takes a scanline, a horizontal pixel column and a plane select (plane A or plane B). It then reads one horizontal offset and one vertical offset from two external scroll memories. It returns the plane pixel coordinates, already reduced to the configured plane size. A renderer uses these coordinates to look up pattern entries. That lookup, and the tile fetch after it, happen outside this block.

Requests arrive on a valid/ready stream and results leave on a valid/ready stream. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In that same cycle the block strobes both scroll memories with their addresses. Each memory must return its word exactly one cycle later. The output holds its value while `out_ready` is low. `req_ready` falls only when the internal stage is occupied and cannot move forward in that cycle. Results leave in request order, one result for each accepted request.

Three configuration registers are written through a plain write port:
- The mode register selects the horizontal mode and the vertical mode.
- A second register holds the byte base address of the horizontal table.
- A third register holds the plane width and plane height codes.

Each request captures the plane size at acceptance. Mode and base address act at acceptance.

Top module: `plane_scroll_sel`

## Requirements
- R1: After reset `out_valid` is 0 and `req_ready` is 1. All registers are zero, which means full-screen horizontal mode, full-screen vertical mode, base address 0, and a plane size of 256x256.
- R2: Mode register (address 0) bits [1:0] select the horizontal mode. Code 0 is full-screen, and code 3 behaves the same. In full-screen mode the horizontal read address is base + 2*plane, with plane A = 0 and plane B = 1.
- R3: Horizontal code 1 is per-row mode. The read address is base + 4*(line rounded down to a multiple of 8) + 2*plane.
- R4: Horizontal code 2 is per-line mode. The read address is base + 4*line + 2*plane. The base is the 16-bit value at register address 1.
- R5: When mode register bit 2 is 0, the vertical read index is the plane number (0 or 1).
- R6: When mode register bit 2 is 1, the vertical read index is 2*(column/16) + plane.
- R7: `out_x` = (column - hoff) mod width. Here hoff is bits [9:0] of the horizontal word. Size register (address 2) bits [1:0] give the width: code 0 is 256, code 1 is 512, codes 2 and 3 are 1024.
- R8: `out_y` = (line + voff) mod height. Here voff is bits [9:0] of the vertical word. Size register bits [5:4] give the height, using the same codes as the width. Bits [15:10] of either memory word have no effect.
- R9: Both memory strobes are high in exactly the cycle a request is accepted. Each memory's data is taken one cycle later.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_x` and `out_y` hold their values. No accepted request is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 mode, 1 horizontal base, 2 plane size |
| cfg_wdata | input | 16 | Configuration write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_line | input | 8 | Scanline of the request |
| req_col | input | 9 | Screen pixel column of the request |
| req_plane | input | 1 | Plane select, 0 = A, 1 = B |
| hs_rd | output | 1 | Horizontal scroll memory read strobe |
| hs_addr | output | 16 | Horizontal scroll memory byte address |
| hs_data | input | 16 | Horizontal scroll word, one cycle after the strobe |
| vs_rd | output | 1 | Vertical scroll memory read strobe |
| vs_idx | output | 6 | Vertical scroll memory entry index |
| vs_data | input | 16 | Vertical scroll word, one cycle after the strobe |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_x | output | 10 | Plane pixel X, wrapped to width |
| out_y | output | 10 | Plane pixel Y, wrapped to height |

## Verification
Two things can happen in the same cycle: a stalled result is held at the output, and the memory words for the next request arrive. Those words must then be parked inside the block. Meanwhile a third request may already be waiting at the input. The bench provokes this case by driving requests back to back while `out_ready` follows a pseudo-random pattern. The scoreboard judges it by comparing every result, in order, against coordinates computed from the memory model's data for that request's addresses. A parked word taken from the wrong request or the wrong cycle shows up as a mismatch.

// File: rtl/scroll_sel_pkg.sv
package scroll_sel_pkg;

  typedef enum logic [1:0] {
    HS_FULL  = 2'd0,
    HS_ROW   = 2'd1,
    HS_LINE  = 2'd2,
    HS_SPARE = 2'd3
  } hs_mode_e;

  localparam logic [1:0] REG_MODE  = 2'd0;
  localparam logic [1:0] REG_HBASE = 2'd1;
  localparam logic [1:0] REG_SIZE  = 2'd2;

  localparam int MODE_VCOL_BIT = 2;
  localparam int SIZE_W_LSB    = 0;
  localparam int SIZE_H_LSB    = 4;

endpackage

// File: rtl/scroll_cfg_regs.sv
module scroll_cfg_regs
  import scroll_sel_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int HADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output hs_mode_e           hmode,
  output logic               vcol,
  output logic [HADDR_W-1:0] hbase,
  output logic [1:0]         wcode,
  output logic [1:0]         hcode
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hmode <= HS_FULL;
      vcol  <= 1'b0;
      hbase <= '0;
      wcode <= 2'd0;
      hcode <= 2'd0;
    end else if (cfg_we) begin
      case (cfg_addr)
        REG_MODE: begin
          hmode <= hs_mode_e'(cfg_wdata[1:0]);
          vcol  <= cfg_wdata[MODE_VCOL_BIT];
        end
        REG_HBASE: hbase <= HADDR_W'(cfg_wdata);
        REG_SIZE: begin
          wcode <= cfg_wdata[SIZE_W_LSB +: 2];
          hcode <= cfg_wdata[SIZE_H_LSB +: 2];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/scroll_addr_gen.sv
module scroll_addr_gen
  import scroll_sel_pkg::*;
#(
  parameter int LINE_W    = 8,
  parameter int COL_W     = 9,
  parameter int HADDR_W   = 16,
  parameter int VIDX_W    = 6,
  parameter int ROW_LINES = 8,
  parameter int COL_PIX   = 16,
  parameter int ENTRY_B   = 2
) (
  input  logic [LINE_W-1:0]  line,
  input  logic [COL_W-1:0]   col,
  input  logic               plane,
  input  hs_mode_e           hmode,
  input  logic               vcol,
  input  logic [HADDR_W-1:0] hbase,
  output logic [HADDR_W-1:0] hs_addr,
  output logic [VIDX_W-1:0]  vs_idx
);

  localparam int ROW_LOG   = $clog2(ROW_LINES);
  localparam int COL_LOG   = $clog2(COL_PIX);
  localparam int ENT_LOG   = $clog2(ENTRY_B);
  localparam int STRIDE_LG = ENT_LOG + 1;

  logic [LINE_W-1:0]  row_line;
  logic [LINE_W-1:0]  sel_line;
  logic [HADDR_W-1:0] line_term;
  logic [HADDR_W-1:0] plane_term;
  logic [VIDX_W-1:0]  col_grp;

  generate
    if (ROW_LOG == 0) begin : g_row_plain
      assign row_line = line;
    end else begin : g_row_mask
      assign row_line = {line[LINE_W-1:ROW_LOG], {ROW_LOG{1'b0}}};
    end
  endgenerate

  always_comb begin
    case (hmode)
      HS_ROW:  sel_line = row_line;
      HS_LINE: sel_line = line;
      default: sel_line = '0;
    endcase
    line_term  = HADDR_W'(sel_line) << STRIDE_LG;
    plane_term = HADDR_W'(plane) << ENT_LOG;
    hs_addr    = hbase + line_term + plane_term;
  end

  always_comb begin
    col_grp = VIDX_W'(col >> COL_LOG);
    if (vcol) vs_idx = (col_grp << 1) | VIDX_W'(plane);
    else      vs_idx = VIDX_W'(plane);
  end

endmodule

// File: rtl/scroll_coord_calc.sv
module scroll_coord_calc #(
  parameter int LINE_W  = 8,
  parameter int COL_W   = 9,
  parameter int OFS_W   = 10,
  parameter int MIN_LOG = 8
) (
  input  logic [LINE_W-1:0] line,
  input  logic [COL_W-1:0]  col,
  input  logic [OFS_W-1:0]  hoff,
  input  logic [OFS_W-1:0]  voff,
  input  logic [1:0]        wcode,
  input  logic [1:0]        hcode,
  output logic [OFS_W-1:0]  px,
  output logic [OFS_W-1:0]  py
);

  function automatic logic [OFS_W-1:0] size_mask(input logic [1:0] code);
    int lg;
    lg = MIN_LOG + int'(code);
    if (lg >= OFS_W) return '1;
    return OFS_W'((1 << lg) - 1);
  endfunction

  logic [OFS_W-1:0] x_raw;
  logic [OFS_W-1:0] y_raw;

  always_comb begin
    x_raw = OFS_W'(col) - hoff;
    y_raw = OFS_W'(line) + voff;
    px    = x_raw & size_mask(wcode);
    py    = y_raw & size_mask(hcode);
  end

endmodule

// File: rtl/plane_scroll_sel.sv
module plane_scroll_sel
  import scroll_sel_pkg::*;
#(
  parameter int LINE_W    = 8,
  parameter int COL_W     = 9,
  parameter int OFS_W     = 10,
  parameter int DATA_W    = 16,
  parameter int HADDR_W   = 16,
  parameter int VIDX_W    = 6,
  parameter int ROW_LINES = 8,
  parameter int COL_PIX   = 16,
  parameter int MIN_LOG   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LINE_W-1:0]  req_line,
  input  logic [COL_W-1:0]   req_col,
  input  logic               req_plane,
  output logic               hs_rd,
  output logic [HADDR_W-1:0] hs_addr,
  input  logic [DATA_W-1:0]  hs_data,
  output logic               vs_rd,
  output logic [VIDX_W-1:0]  vs_idx,
  input  logic [DATA_W-1:0]  vs_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [OFS_W-1:0]   out_x,
  output logic [OFS_W-1:0]   out_y
);

  hs_mode_e           hmode;
  logic               vcol;
  logic [HADDR_W-1:0] hbase;
  logic [1:0]         wcode;
  logic [1:0]         hcode;

  scroll_cfg_regs #(.DATA_W(DATA_W), .HADDR_W(HADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hmode(hmode), .vcol(vcol), .hbase(hbase),
    .wcode(wcode), .hcode(hcode)
  );

  scroll_addr_gen #(
    .LINE_W(LINE_W), .COL_W(COL_W), .HADDR_W(HADDR_W), .VIDX_W(VIDX_W),
    .ROW_LINES(ROW_LINES), .COL_PIX(COL_PIX), .ENTRY_B(2)
  ) u_addr (
    .line(req_line), .col(req_col), .plane(req_plane), .hmode(hmode),
    .vcol(vcol), .hbase(hbase), .hs_addr(hs_addr), .vs_idx(vs_idx)
  );

  // Stage 1: request waiting for (or holding) its scroll words.
  logic              s1_valid;
  logic              s1_fresh;
  logic [LINE_W-1:0] s1_line;
  logic [COL_W-1:0]  s1_col;
  logic [1:0]        s1_wcode;
  logic [1:0]        s1_hcode;
  logic [OFS_W-1:0]  s1_hoff_q;
  logic [OFS_W-1:0]  s1_voff_q;
  logic [OFS_W-1:0]  hoff_sel;
  logic [OFS_W-1:0]  voff_sel;
  logic [OFS_W-1:0]  calc_x;
  logic [OFS_W-1:0]  calc_y;
  logic              accept;
  logic              s2_load;

  assign s2_load   = s1_valid && (!out_valid || out_ready);
  assign req_ready = !s1_valid || s2_load;
  assign accept    = req_valid && req_ready;
  assign hs_rd     = accept;
  assign vs_rd     = accept;

  assign hoff_sel = s1_fresh ? hs_data[OFS_W-1:0] : s1_hoff_q;
  assign voff_sel = s1_fresh ? vs_data[OFS_W-1:0] : s1_voff_q;

  logic unused_hi;
  assign unused_hi = ^{hs_data[DATA_W-1:OFS_W], vs_data[DATA_W-1:OFS_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_fresh  <= 1'b0;
      s1_line   <= '0;
      s1_col    <= '0;
      s1_wcode  <= 2'd0;
      s1_hcode  <= 2'd0;
      s1_hoff_q <= '0;
      s1_voff_q <= '0;
    end else begin
      if (accept) begin
        s1_valid <= 1'b1;
        s1_line  <= req_line;
        s1_col   <= req_col;
        s1_wcode <= wcode;
        s1_hcode <= hcode;
      end else if (s2_load) begin
        s1_valid <= 1'b0;
      end
      s1_fresh <= accept;
      if (s1_valid && s1_fresh && !s2_load) begin
        s1_hoff_q <= hs_data[OFS_W-1:0];
        s1_voff_q <= vs_data[OFS_W-1:0];
      end
    end
  end

  scroll_coord_calc #(
    .LINE_W(LINE_W), .COL_W(COL_W), .OFS_W(OFS_W), .MIN_LOG(MIN_LOG)
  ) u_calc (
    .line(s1_line), .col(s1_col), .hoff(hoff_sel), .voff(voff_sel),
    .wcode(s1_wcode), .hcode(s1_hcode), .px(calc_x), .py(calc_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
    end else if (s2_load) begin
      out_valid <= 1'b1;
      out_x     <= calc_x;
      out_y     <= calc_y;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/scroll_sel_chk.sv
module scroll_sel_chk #(
  parameter int LINE_W  = 8,
  parameter int COL_W   = 9,
  parameter int OFS_W   = 10,
  parameter int DATA_W  = 16,
  parameter int HADDR_W = 16,
  parameter int VIDX_W  = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [1:0]         cfg_addr,
  input logic [DATA_W-1:0]  cfg_wdata,
  input logic               req_valid,
  input logic               req_ready,
  input logic [LINE_W-1:0]  req_line,
  input logic [COL_W-1:0]   req_col,
  input logic               req_plane,
  input logic               hs_rd,
  input logic [HADDR_W-1:0] hs_addr,
  input logic               vs_rd,
  input logic [VIDX_W-1:0]  vs_idx,
  input logic               out_valid,
  input logic               out_ready,
  input logic [OFS_W-1:0]   out_x,
  input logic [OFS_W-1:0]   out_y
);

  logic [1:0]         sh_mode;
  logic               sh_vcol;
  logic [HADDR_W-1:0] sh_base;
  logic               acc;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_mode <= 2'd0;
      sh_vcol <= 1'b0;
      sh_base <= '0;
    end else if (cfg_we && cfg_addr == 2'd0) begin
      sh_mode <= cfg_wdata[1:0];
      sh_vcol <= cfg_wdata[2];
    end else if (cfg_we && cfg_addr == 2'd1) begin
      sh_base <= HADDR_W'(cfg_wdata);
    end
  end

  a_r2_full_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (sh_mode == 2'd0 || sh_mode == 2'd3)) |->
      hs_addr == sh_base + HADDR_W'({req_plane, 1'b0}));

  a_r3_row_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sh_mode == 2'd1) |->
      hs_addr == sh_base + (HADDR_W'({req_line[LINE_W-1:3], 3'b000}) << 2)
                 + HADDR_W'({req_plane, 1'b0}));

  a_r4_line_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sh_mode == 2'd2) |->
      hs_addr == sh_base + (HADDR_W'(req_line) << 2) + HADDR_W'({req_plane, 1'b0}));

  a_r5_vfull_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !sh_vcol) |-> vs_idx == VIDX_W'(req_plane));

  a_r6_vcol_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sh_vcol) |-> vs_idx == VIDX_W'({req_col[COL_W-1:4], req_plane}));

  a_r9_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rd || vs_rd) |-> (acc && hs_rd && vs_rd));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y)));

  logic unused_chk;
  assign unused_chk = ^{cfg_wdata, out_valid};

endmodule

bind plane_scroll_sel scroll_sel_chk #(
  .LINE_W(LINE_W), .COL_W(COL_W), .OFS_W(OFS_W), .DATA_W(DATA_W),
  .HADDR_W(HADDR_W), .VIDX_W(VIDX_W)
) u_chk (.*);

// File: tb/plane_scroll_sel_test.sv
`timescale 1ns/100ps
module plane_scroll_sel_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_line = '0;
  logic [8:0]  req_col = '0;
  logic        req_plane = 1'b0;
  logic        hs_rd;
  logic [15:0] hs_addr;
  logic [15:0] hs_data = '0;
  logic        vs_rd;
  logic [5:0]  vs_idx;
  logic [15:0] vs_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [9:0]  out_x;
  logic [9:0]  out_y;

  always #2 clk = ~clk;

  plane_scroll_sel uut (.*);

  int n_checks = 0;
  int n_fail   = 0;
  logic stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [1:0]  b_hmode = 0;
  logic        b_vcol = 0;
  logic [15:0] b_base = 0;
  logic [1:0]  b_wcode = 0;
  logic [1:0]  b_hcode = 0;

  logic [9:0]  q_x[$];
  logic [9:0]  q_y[$];
  string       q_tag[$];

  function automatic logic [15:0] hfun(input logic [15:0] a);
    return a * 16'd37 + 16'hA5C3;
  endfunction

  function automatic logic [15:0] vfun(input logic [5:0] i);
    return {10'd0, i} * 16'd91 + 16'h7E21;
  endfunction

  function automatic logic [9:0] mask_of(input logic [1:0] c);
    case (c)
      2'd0: return 10'd255;
      2'd1: return 10'd511;
      default: return 10'd1023;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory models, one-cycle latency
  always @(posedge clk) begin
    if (hs_rd) hs_data <= hfun(hs_addr);
    if (vs_rd) vs_data <= vfun(vs_idx);
  end

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = stall_mode ? lfsr[0] : 1'b1;
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (out_valid && out_ready) begin
        if (q_x.size() == 0) begin
          chk(0, "R10 unexpected result", int'(out_x), -1);
        end else begin
          logic [9:0] ex, ey;
          string tg;
          ex = q_x.pop_front();
          ey = q_y.pop_front();
          tg = q_tag.pop_front();
          chk(out_x == ex, {tg, " out_x R7"}, int'(out_x), int'(ex));
          chk(out_y == ey, {tg, " out_y R8"}, int'(out_y), int'(ey));
        end
      end
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 2'd0) begin b_hmode = d[1:0]; b_vcol = d[2]; end
    if (a == 2'd1) b_base = d;
    if (a == 2'd2) begin b_wcode = d[1:0]; b_hcode = d[5:4]; end
  endtask

  task automatic send(input logic [7:0] ln, input logic [8:0] cl, input logic pl,
                      input string tag);
    logic [15:0] ea;
    logic [5:0]  ei;
    logic [7:0]  sl;
    logic [9:0]  ho, vo;
    case (b_hmode)
      2'd1: sl = {ln[7:3], 3'b000};
      2'd2: sl = ln;
      default: sl = 8'd0;
    endcase
    ea = b_base + 16'(sl) * 16'd4 + 16'(pl) * 16'd2;
    ei = b_vcol ? 6'((cl / 16) * 2 + pl) : 6'(pl);
    ho = hfun(ea)[9:0];
    vo = vfun(ei)[9:0];
    @(negedge clk);
    req_valid = 1'b1; req_line = ln; req_col = cl; req_plane = pl;
    #0.5;
    while (!req_ready) begin
      @(negedge clk);
      #0.5;
    end
    chk(hs_rd && vs_rd, {tag, " strobes R9"}, int'(hs_rd), 1);
    chk(hs_addr == ea, {tag, " hs_addr R2/R3/R4"}, int'(hs_addr), int'(ea));
    chk(vs_idx == ei, {tag, " vs_idx R5/R6"}, int'(vs_idx), int'(ei));
    q_x.push_back((10'(cl) - ho) & mask_of(b_wcode));
    q_y.push_back((10'(ln) + vo) & mask_of(b_hcode));
    q_tag.push_back(tag);
    @(posedge clk);
    #0.1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while ((q_x.size() != 0 || out_valid) && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(q_x.size() == 0, "R10 drain", q_x.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);

    // R1 / R2: default config, full-screen, base 0, 256x256
    send(8'd10, 9'd100, 1'b0, "R1 default A");
    send(8'd10, 9'd100, 1'b1, "R1 default B");
    send(8'd200, 9'd3, 1'b0, "R2 full wrap");
    drain();

    // R4: per-line, base F000, width 512, height 256
    cfg_write(2'd1, 16'hF000);
    cfg_write(2'd0, 16'h0002);
    cfg_write(2'd2, 16'h0001);
    for (int i = 0; i < 6; i++) begin
      send(8'(i * 37 + 1), 9'(i * 53), 1'(i), "R4 line");
    end
    send(8'd223, 9'd319, 1'b1, "R4 last line");
    drain();

    // R3: per-row, width 1024, height 1024
    cfg_write(2'd0, 16'h0001);
    cfg_write(2'd2, 16'h0023);
    send(8'd0, 9'd0, 1'b0, "R3 row0");
    send(8'd7, 9'd5, 1'b0, "R3 row0 end");
    send(8'd8, 9'd5, 1'b1, "R3 row1");
    send(8'd15, 9'd250, 1'b1, "R3 row1 end");
    send(8'd223, 9'd318, 1'b0, "R3 last row");
    drain();

    // R6: column vertical mode, full horizontal, height code 1
    cfg_write(2'd0, 16'h0004);
    cfg_write(2'd2, 16'h0012);
    send(8'd50, 9'd0, 1'b0, "R6 col0");
    send(8'd50, 9'd15, 1'b1, "R6 col0 edge");
    send(8'd50, 9'd16, 1'b0, "R6 col1");
    send(8'd99, 9'd319, 1'b1, "R6 col19");
    drain();

    // R2: spare horizontal code acts as full-screen
    cfg_write(2'd1, 16'h1234);
    cfg_write(2'd0, 16'h0003);
    send(8'd77, 9'd140, 1'b1, "R2 code3");
    send(8'd78, 9'd141, 1'b0, "R2 code3 A");
    drain();

    // R10: back-pressure with back-to-back requests
    cfg_write(2'd0, 16'h0006);
    cfg_write(2'd2, 16'h0010);
    stall_mode = 1'b1;
    for (int i = 0; i < 60; i++) begin
      send(8'((i * 29) % 224), 9'((i * 71) % 320), 1'(i >> 1), "R10 stall");
    end
    drain();
    stall_mode = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule